// File: doc/BRIEF.md
# Two-Channel Credit Link Arbiter

This block puts two virtual channels onto one shared physical link. Channel 0 carries a wide read stream and channel 1 carries a wide write stream. Each channel has its own input handshake and an opaque payload word. Each flit leaves the block together with a one-bit channel tag, so the far side can place it in the correct buffer.

A mode parameter selects how the two channels share the link. In credit mode, the block holds a downstream credit count for each channel and sends a flit only when that count is nonzero. A round-robin pointer settles any contest between the two channels. The block echoes every accepted input flit upstream as a credit pulse one cycle later. In preempt mode, the read channel takes the link whenever it has data, even in the middle of a write stream. The credit outputs are then held at 1, and the downstream ready gates acceptance.

Top module: `vc_link_arb`

## Requirements
- R1: While reset is asserted and in the first cycle after release, `up_credit_o` is 0 in credit mode, and `link_valid_o` is 0 when no input is valid. Both credit counters start at `CreditDepth`.
- R2: In credit mode, `up_credit_o[v]` equals `vc_valid_i[v] & vc_ready_o[v]` from the previous clock cycle.
- R3: In credit mode, a channel whose credit count is zero is never granted. With no credit returned, a channel stops after `CreditDepth` flits.
- R4: In credit mode, a grant decrements that channel's count and a `down_credit_i[v]` pulse increments it. If both happen in the same cycle, the count is unchanged.
- R5: In credit mode, when both channels are eligible, the round-robin pointer picks the winner. The pointer starts at channel 0 after reset and, after every grant, points at the other channel.
- R6: In credit mode, when only one channel is eligible, that channel is granted whatever the pointer holds.
- R7: `link_vc_o` is 0 for a read-channel flit and 1 for a write-channel flit. `link_data_o` equals the payload of the granted channel.
- R8: At most one bit of `vc_ready_o` is high in any cycle, and only for a valid channel. In credit mode, `link_valid_o` is high exactly when some channel is granted, and `link_ready_i` has no effect.
- R9: In preempt mode, `up_credit_o` is all ones. The read channel wins whenever it is valid, and the write channel is granted only in cycles where the read channel is not valid.
- R10: In preempt mode, `link_valid_o` is high when any channel is valid, and `vc_ready_o` of the granted channel equals `link_ready_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vc_valid_i | input | 2 | Per-channel input valid (bit 0 read, bit 1 write) |
| vc_ready_o | output | 2 | Per-channel input ready |
| vc_data_i | input | 2 x DataWidth | Per-channel payload |
| up_credit_o | output | 2 | Credit pulses returned upstream |
| link_valid_o | output | 1 | Shared link valid |
| link_ready_i | input | 1 | Shared link ready (used in preempt mode only) |
| link_vc_o | output | 1 | Channel tag of the flit on the link |
| link_data_o | output | DataWidth | Payload on the shared link |
| down_credit_i | input | 2 | Credit pulses returned from downstream |

## Verification
A credit count that is off by one shows up at the ports within a few flits. Either a channel is still granted after its `CreditDepth`-th flit with no credit back, or it stays stalled in a cycle where a returned credit should have freed it. A round-robin pointer that does not move shows on the very next contested cycle, because the same channel wins twice. A credit echo that is wrong, delayed or missing is visible in the cycle right after the accepted flit.

// File: rtl/vc_link_pkg.sv
package vc_link_pkg;

  typedef enum logic {
    FLOW_CREDIT  = 1'b0,
    FLOW_PREEMPT = 1'b1
  } flow_mode_e;

  typedef enum logic {
    VC_RD = 1'b0,
    VC_WR = 1'b1
  } vc_id_e;

  localparam int unsigned NumVc = 2;

endpackage

// File: rtl/vc_credit_counter.sv
module vc_credit_counter #(
  parameter int unsigned CreditDepth = 4,
  localparam int unsigned CntW = $clog2(CreditDepth + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic            give_i,
  output logic            avail_o,
  output logic [CntW-1:0] count_o
);

  logic [CntW-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  // The count moves only when exactly one of take/give is active.
  assign cnt_en = take_i ^ give_i;

  always_comb begin
    cnt_d = cnt_q;
    if (give_i && !take_i) begin
      cnt_d = cnt_q + CntW'(1);
    end else if (take_i && !give_i) begin
      cnt_d = cnt_q - CntW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CntW'(CreditDepth);
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign avail_o = (cnt_q != '0);
  assign count_o = cnt_q;

endmodule

// File: rtl/vc_credit_return.sv
module vc_credit_return
  import vc_link_pkg::*;
#(
  parameter flow_mode_e FlowMode = FLOW_CREDIT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NumVc-1:0] hs_valid_i,
  input  logic [NumVc-1:0] hs_ready_i,
  output logic [NumVc-1:0] credit_o
);

  if (FlowMode == FLOW_CREDIT) begin : g_registered
    logic [NumVc-1:0] echo_q, echo_d;

    assign echo_d = hs_valid_i & hs_ready_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        echo_q <= '0;
      end else begin
        echo_q <= echo_d;
      end
    end

    assign credit_o = echo_q;
  end else begin : g_tied
    assign credit_o = '1;
  end

endmodule

// File: rtl/vc_link_pick.sv
module vc_link_pick
  import vc_link_pkg::*;
#(
  parameter flow_mode_e FlowMode = FLOW_CREDIT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NumVc-1:0] req_i,
  input  logic [NumVc-1:0] avail_i,
  output logic [NumVc-1:0] gnt_o,
  output logic             sel_o
);

  if (FlowMode == FLOW_CREDIT) begin : g_rr
    logic [NumVc-1:0] elig;
    logic             ptr_q, ptr_d;
    logic             ptr_en;

    assign elig = req_i & avail_i;

    always_comb begin
      gnt_o = '0;
      sel_o = ptr_q;
      if (elig == 2'b11) begin
        gnt_o[ptr_q] = 1'b1;
        sel_o        = ptr_q;
      end else if (elig[VC_RD]) begin
        gnt_o[VC_RD] = 1'b1;
        sel_o        = VC_RD;
      end else if (elig[VC_WR]) begin
        gnt_o[VC_WR] = 1'b1;
        sel_o        = VC_WR;
      end
    end

    assign ptr_en = |gnt_o;
    assign ptr_d  = ~sel_o;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_q <= VC_RD;
      end else if (ptr_en) begin
        ptr_q <= ptr_d;
      end
    end
  end else begin : g_preempt
    // Read stream pre-empts the write stream whenever it is valid.
    always_comb begin
      gnt_o = '0;
      sel_o = VC_RD;
      if (req_i[VC_RD]) begin
        gnt_o[VC_RD] = 1'b1;
      end else if (req_i[VC_WR]) begin
        gnt_o[VC_WR] = 1'b1;
        sel_o        = VC_WR;
      end
    end
  end

endmodule

// File: rtl/vc_link_arb.sv
module vc_link_arb
  import vc_link_pkg::*;
#(
  parameter int unsigned DataWidth   = 32,
  parameter int unsigned CreditDepth = 4,
  parameter flow_mode_e  FlowMode    = FLOW_CREDIT,
  localparam int unsigned CntW       = $clog2(CreditDepth + 1)
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NumVc-1:0]                    vc_valid_i,
  output logic [NumVc-1:0]                    vc_ready_o,
  input  logic [NumVc-1:0][DataWidth-1:0]     vc_data_i,
  output logic [NumVc-1:0]                    up_credit_o,
  output logic                                link_valid_o,
  input  logic                                link_ready_i,
  output logic                                link_vc_o,
  output logic [DataWidth-1:0]                link_data_o,
  input  logic [NumVc-1:0]                    down_credit_i
);

  logic [NumVc-1:0]           avail;
  logic [NumVc-1:0]           gnt;
  logic                       sel;
  logic [NumVc-1:0][CntW-1:0] cred_cnt;

  for (genvar v = 0; v < NumVc; v++) begin : g_vc
    if (FlowMode == FLOW_CREDIT) begin : g_cnt
      vc_credit_counter #(
        .CreditDepth (CreditDepth)
      ) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .take_i  (gnt[v]),
        .give_i  (down_credit_i[v]),
        .avail_o (avail[v]),
        .count_o (cred_cnt[v])
      );
    end else begin : g_nocnt
      assign avail[v]    = 1'b1;
      assign cred_cnt[v] = CntW'(CreditDepth);
    end
  end

  vc_link_pick #(
    .FlowMode (FlowMode)
  ) u_pick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (vc_valid_i),
    .avail_i (avail),
    .gnt_o   (gnt),
    .sel_o   (sel)
  );

  if (FlowMode == FLOW_CREDIT) begin : g_out_credit
    assign vc_ready_o   = gnt;
    assign link_valid_o = |gnt;
  end else begin : g_out_preempt
    assign vc_ready_o   = gnt & {NumVc{link_ready_i}};
    assign link_valid_o = |vc_valid_i;
  end

  assign link_vc_o   = sel;
  assign link_data_o = vc_data_i[sel];

  vc_credit_return #(
    .FlowMode (FlowMode)
  ) u_ret (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hs_valid_i (vc_valid_i),
    .hs_ready_i (vc_ready_o),
    .credit_o   (up_credit_o)
  );

endmodule

// File: rtl/vc_link_arb_chk.sv
module vc_link_arb_chk
  import vc_link_pkg::*;
#(
  parameter int unsigned CreditDepth = 4,
  parameter flow_mode_e  FlowMode    = FLOW_CREDIT,
  localparam int unsigned CntW       = $clog2(CreditDepth + 1)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NumVc-1:0]           vc_valid_i,
  input logic [NumVc-1:0]           vc_ready_o,
  input logic [NumVc-1:0]           up_credit_o,
  input logic                       link_valid_o,
  input logic                       link_vc_o,
  input logic [NumVc-1:0][CntW-1:0] cnt_i
);

  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  logic [NumVc-1:0] elig;
  assign elig = {cnt_i[1] != '0, cnt_i[0] != '0} & vc_valid_i;

  assert_onehot_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(vc_ready_o));

  assert_ready_tag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|vc_ready_o) |-> (vc_ready_o[link_vc_o] && vc_valid_i[link_vc_o] && link_valid_o));

  if (FlowMode == FLOW_CREDIT) begin : g_credit
    assert_credit_echo_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      live_q |-> (up_credit_o == $past(vc_valid_i & vc_ready_o)));

    assert_no_send_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vc_ready_o[0] |-> cnt_i[0] != '0) and (vc_ready_o[1] |-> cnt_i[1] != '0));

    assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_i[0] <= CntW'(CreditDepth)) && (cnt_i[1] <= CntW'(CreditDepth)));

    assert_rr_alternate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && elig == 2'b11 && $past(elig == 2'b11 && vc_ready_o[0])) |-> vc_ready_o[1]);

    assert_single_elig_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (elig == 2'b10) |-> vc_ready_o[1]);
  end else begin : g_preempt
    assert_credit_tied_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      up_credit_o == 2'b11);

    assert_read_preempts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vc_valid_i[0] |-> !vc_ready_o[1]);

    assert_link_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      link_valid_o == (|vc_valid_i));
  end

endmodule

bind vc_link_arb vc_link_arb_chk #(
  .CreditDepth (CreditDepth),
  .FlowMode    (FlowMode)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .vc_valid_i   (vc_valid_i),
  .vc_ready_o   (vc_ready_o),
  .up_credit_o  (up_credit_o),
  .link_valid_o (link_valid_o),
  .link_vc_o    (link_vc_o),
  .cnt_i        (cred_cnt)
);

// File: tb/vc_link_arb_bench.sv
module vc_link_arb_bench;
  import vc_link_pkg::*;

  localparam int unsigned DW = 32;

  logic clk = 1'b0;
  logic rst_ni;
  always #10 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;

  // credit-mode instance
  logic [1:0]         c_valid, c_ready, c_upcred, c_dcred;
  logic [1:0][DW-1:0] c_data;
  logic               c_lvalid, c_lready, c_lvc;
  logic [DW-1:0]      c_ldata;

  vc_link_arb #(.DataWidth(DW), .CreditDepth(4), .FlowMode(FLOW_CREDIT)) u_vc_link_arb (
    .clk_i(clk), .rst_ni(rst_ni),
    .vc_valid_i(c_valid), .vc_ready_o(c_ready), .vc_data_i(c_data),
    .up_credit_o(c_upcred), .link_valid_o(c_lvalid), .link_ready_i(c_lready),
    .link_vc_o(c_lvc), .link_data_o(c_ldata), .down_credit_i(c_dcred)
  );

  // preempt-mode instance
  logic [1:0]         p_valid, p_ready, p_upcred;
  logic [1:0][DW-1:0] p_data;
  logic               p_lvalid, p_lready, p_lvc;
  logic [DW-1:0]      p_ldata;

  vc_link_arb #(.DataWidth(DW), .CreditDepth(4), .FlowMode(FLOW_PREEMPT)) u_vc_link_arb_pre (
    .clk_i(clk), .rst_ni(rst_ni),
    .vc_valid_i(p_valid), .vc_ready_o(p_ready), .vc_data_i(p_data),
    .up_credit_o(p_upcred), .link_valid_o(p_lvalid), .link_ready_i(p_lready),
    .link_vc_o(p_lvc), .link_data_o(p_ldata), .down_credit_i(2'b00)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Row: {valid[1:0], link_ready, down_credit[1:0], exp_lvalid, exp_vc, exp_ready[1:0]}
  localparam int NROWS = 19;
  localparam logic [8:0] TBL [NROWS] = '{
    {2'b11, 1'b1, 2'b00, 1'b1, 1'b0, 2'b01}, // R5 ptr 0 wins
    {2'b11, 1'b1, 2'b00, 1'b1, 1'b1, 2'b10}, // R5 alternate
    {2'b11, 1'b0, 2'b00, 1'b1, 1'b0, 2'b01}, // R8 link_ready ignored
    {2'b01, 1'b1, 2'b00, 1'b1, 1'b0, 2'b01}, // R6 only read
    {2'b00, 1'b1, 2'b00, 1'b0, 1'b0, 2'b00}, // idle
    {2'b11, 1'b1, 2'b00, 1'b1, 1'b1, 2'b10}, // R5 ptr at write
    {2'b01, 1'b1, 2'b00, 1'b1, 1'b0, 2'b01}, // read uses last credit
    {2'b01, 1'b1, 2'b00, 1'b0, 1'b0, 2'b00}, // R3 read empty
    {2'b11, 1'b1, 2'b00, 1'b1, 1'b1, 2'b10}, // R6 only write eligible
    {2'b01, 1'b1, 2'b01, 1'b0, 1'b0, 2'b00}, // R4 credit arrives, count still 0
    {2'b01, 1'b0, 2'b00, 1'b1, 1'b0, 2'b01}, // R4 freed read
    {2'b11, 1'b1, 2'b01, 1'b1, 1'b1, 2'b10}, // write last credit
    {2'b11, 1'b1, 2'b00, 1'b1, 1'b0, 2'b01}, // R6 only read eligible
    {2'b11, 1'b1, 2'b11, 1'b0, 1'b0, 2'b00}, // R3 both empty
    {2'b11, 1'b1, 2'b01, 1'b1, 1'b1, 2'b10}, // R5 ptr at write
    {2'b01, 1'b1, 2'b01, 1'b1, 1'b0, 2'b01}, // R4 send+credit same cycle
    {2'b01, 1'b0, 2'b00, 1'b1, 1'b0, 2'b01}, // R4 count was held at 2
    {2'b01, 1'b1, 2'b00, 1'b1, 1'b0, 2'b01}, // R4 second of two
    {2'b01, 1'b1, 2'b00, 1'b0, 1'b0, 2'b00}  // R3 stalled again
  };

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin : main
    logic [1:0] prev_rdy;
    rst_ni   = 1'b0;
    c_valid  = '0; c_lready = 1'b1; c_dcred = '0;
    p_valid  = '0; p_lready = 1'b1;
    c_data   = '0; p_data   = '0;
    repeat (3) @(posedge clk);
    #5;
    check("R1 credit in reset", 64'(c_upcred), 64'(2'b00));
    check("R1 link idle in reset", 64'(c_lvalid), 64'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk);
    #5;
    check("R1 credit after release", 64'(c_upcred), 64'(2'b00));

    prev_rdy = 2'b00;
    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      c_valid   = TBL[i][8:7];
      c_lready  = TBL[i][6];
      c_dcred   = TBL[i][5:4];
      c_data[0] = 32'hA000_0000 + 32'(i);
      c_data[1] = 32'hB000_0000 + 32'(i);
      #5;
      check($sformatf("R2 echo row %0d", i), 64'(c_upcred), 64'(prev_rdy));
      check($sformatf("R8 link_valid row %0d", i), 64'(c_lvalid), 64'(TBL[i][3]));
      check($sformatf("R3/R5/R6 ready row %0d", i), 64'(c_ready), 64'(TBL[i][1:0]));
      if (TBL[i][3]) begin
        check($sformatf("R7 tag row %0d", i), 64'(c_lvc), 64'(TBL[i][2]));
        check($sformatf("R7 data row %0d", i), 64'(c_ldata), 64'(c_data[TBL[i][2]]));
      end
      prev_rdy = TBL[i][1:0];
    end
    @(negedge clk);
    c_valid = '0; c_dcred = '0;
    #5;
    check("R2 echo final", 64'(c_upcred), 64'(prev_rdy));

    // Preempt mode directed checks
    p_data[0] = 32'h1111_1111;
    p_data[1] = 32'h2222_2222;
    p_valid = 2'b11; p_lready = 1'b1;
    #2;
    check("R9 credit tied", 64'(p_upcred), 64'(2'b11));
    check("R9 read wins", 64'(p_ready), 64'(2'b01));
    check("R7 preempt tag read", 64'(p_lvc), 64'd0);
    check("R7 preempt data read", 64'(p_ldata), 64'(32'h1111_1111));
    @(negedge clk);
    p_valid = 2'b10;
    #2;
    check("R9 write alone", 64'(p_ready), 64'(2'b10));
    check("R7 preempt tag write", 64'(p_lvc), 64'd1);
    check("R7 preempt data write", 64'(p_ldata), 64'(32'h2222_2222));
    @(negedge clk);
    p_valid = 2'b11;
    #2;
    check("R9 read preempts write", 64'(p_ready), 64'(2'b01));
    @(negedge clk);
    p_valid = 2'b11; p_lready = 1'b0;
    #2;
    check("R10 stalled link valid", 64'(p_lvalid), 64'd1);
    check("R10 ready follows link", 64'(p_ready), 64'(2'b00));
    @(negedge clk);
    p_valid = 2'b10; p_lready = 1'b0;
    #2;
    check("R10 write stalled", 64'(p_ready), 64'(2'b00));
    @(negedge clk);
    p_valid = 2'b00; p_lready = 1'b1;
    #2;
    check("R10 idle", 64'(p_lvalid), 64'd0);
    check("R9 credit still tied", 64'(p_upcred), 64'(2'b11));

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule